// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver with Address Filtering

This block recovers asynchronous serial frames from one input line. A clock-enable pulse arrives at sixteen times the bit rate. The idle line is high. Each frame begins with a low start bit, carries eight data bits least significant first, and ends with a high stop bit. In the long format a ninth data bit sits between the data and the stop bit. Every bit is decided by a two-of-three vote over samples taken in the middle of the bit. A start bit that does not vote low is treated as noise, and the receiver goes back to watching the line.

A received frame is handed over through a byte register, an extra-bit register and a sticky done flag that software clears. In the short format the extra bit is the stop bit. In the long format it is the ninth data bit. A new frame is delivered only when the done flag is already clear. With address filtering on, a frame is delivered only when its extra bit is 1. Any frame that is not delivered is dropped without a trace. This lets a node on a shared multidrop line sleep through data frames meant for other nodes and wake only on address frames.

A nine-bit shift register is preset to all ones when a frame starts. Bits enter at the top end and ones fall out at the bottom end. When the start bit reaches the bottom cell, the frame is complete, and that one condition triggers the final shift and the delivery decision.

Top module: `mpuart_rx`

## Requirements
- R1: While `rst` is high, and after it is released, `rx_data` is 0, `rx_extra` is 0 and `rx_done` is 0. The receiver starts out waiting for a start edge.
- R2: With `fmt11`=0 a frame is start, 8 data bits LSB first, stop. The data goes to `rx_data` and the stop bit goes to `rx_extra`. With `fmt11`=1 a ninth data bit follows the 8 data bits. The ninth bit goes to `rx_extra`.
- R3: While waiting and enabled, a start is detected on a `tick` where the synchronized line is 0 and was 1 on the previous `tick`. If the voted start bit is 1, the frame is abandoned and the receiver waits for a new edge without changing any output.
- R4: The detection tick is counter state 0, and the states run 0 to 15 per bit. Each bit is the majority of the synchronized line at states 7, 8 and 9, so a disturbance that lasts a single tick does not change the received value.
- R5: A frame is delivered only if `rx_done` is 0 and either `filter_en` is 0 or the received extra bit is 1. Otherwise `rx_data`, `rx_extra` and `rx_done` keep their values.
- R6: `rx_done` is set by a delivery and stays set until a clock with `flag_clr` high clears it. If a delivery and `flag_clr` happen in the same clock, the flag ends up set.
- R7: The delivery decision is made on the state-9 tick of the tenth bit of the frame, counting the start bit as the first. In the short format that is the middle of the stop bit, and the receiver waits for a new edge from then on. In the long format it waits one more bit time, until the state-9 tick of the stop bit. The outputs change on the clock edge of the decision tick.
- R8: While `rx_en` is 0 the receiver is held waiting and delivers nothing. A frame in progress is abandoned.
- R9: `rx_line` passes through two flip-flops before it is sampled, so a change on the pin is seen two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| fmt11 | input | 1 | 1 = long format with ninth data bit, 0 = short format |
| filter_en | input | 1 | Address filter: deliver only frames whose extra bit is 1 |
| flag_clr | input | 1 | Clears `rx_done` |
| rx_data | output | 8 | Last delivered data byte |
| rx_extra | output | 1 | Last delivered stop bit (short format) or ninth bit (long format) |
| rx_done | output | 1 | Sticky frame-delivered flag |

## Verification
Clean frames in both formats, with the extra bit at 0 and at 1, separate where the extra bit is taken from and how the filter and done-flag gating combine. A frame sent while the flag is still set is expected to be lost; when the flag is cleared partway through a back-to-back frame, that frame is expected to be delivered. This shows that acceptance depends on the flag at decision time and that each format returns to edge search at the point it should. A short low pulse on an idle line tells start-bit validation apart from plain edge triggering. A one-tick glitch inside a data bit tells majority voting apart from single-point sampling. A frame sent with the receiver disabled shows that the enable really gates the line. The flag is sampled both just after the stop bit starts and at its end, which pins the delivery to the middle of the stop bit.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BITS = 2'd1,
    ST_TAIL = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpuart_rx_vote.sv
module mpuart_rx_vote #(
  parameter int CNT_W = 4,
  parameter int S_LO  = 7,
  parameter int S_MID = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             line,
  output logic             vote
);
  logic samp_a, samp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (en) begin
      if (cnt == CNT_W'(S_LO))  samp_a <= line;
      if (cnt == CNT_W'(S_MID)) samp_b <= line;
    end
  end

  // third sample is the live line on the deciding tick
  assign vote = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic              fmt11,
  input  logic              filter_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_extra,
  output logic              rx_done
);
  localparam int CNT_W = $clog2(OVS);
  localparam int SH_W  = DATA_W + 1;
  localparam int S_MID = OVS / 2;
  localparam int S_LO  = S_MID - 1;
  localparam int S_HI  = S_MID + 1;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  shreg;
  logic             first_bit;
  logic             prev_line;
  logic             line;
  logic             vote;
  logic             at_decide;
  logic             accept;

  mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_line),
    .q   (line)
  );

  mpuart_rx_vote #(.CNT_W(CNT_W), .S_LO(S_LO), .S_MID(S_MID)) u_vote (
    .clk  (clk),
    .rst  (rst),
    .en   (tick && (state == ST_BITS)),
    .cnt  (cnt),
    .line (line),
    .vote (vote)
  );

  assign at_decide = (cnt == CNT_W'(S_HI));
  assign accept    = !rx_done && (!filter_en || vote);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      cnt       <= '0;
      shreg     <= '1;
      first_bit <= 1'b0;
      prev_line <= 1'b1;
      rx_data   <= '0;
      rx_extra  <= 1'b0;
      rx_done   <= 1'b0;
    end else begin
      if (flag_clr) rx_done <= 1'b0;
      if (tick) prev_line <= line;
      if (!rx_en) begin
        state <= ST_HUNT;
      end else if (tick) begin
        unique case (state)
          ST_HUNT: begin
            if (prev_line && !line) begin
              state     <= ST_BITS;
              cnt       <= CNT_W'(1);
              shreg     <= '1;
              first_bit <= 1'b1;
            end
          end
          ST_BITS: begin
            cnt <= (cnt == CNT_W'(OVS - 1)) ? '0 : cnt + 1'b1;
            if (at_decide) begin
              first_bit <= 1'b0;
              if (first_bit && vote) begin
                state <= ST_HUNT;
              end else if (!shreg[0]) begin
                shreg <= {vote, shreg[SH_W-1:1]};
                if (accept) begin
                  rx_data  <= shreg[SH_W-1:1];
                  rx_extra <= vote;
                  rx_done  <= 1'b1;
                end
                state <= fmt11 ? ST_TAIL : ST_HUNT;
              end else begin
                shreg <= {vote, shreg[SH_W-1:1]};
              end
            end
          end
          ST_TAIL: begin
            cnt <= (cnt == CNT_W'(OVS - 1)) ? '0 : cnt + 1'b1;
            if (at_decide) state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              rx_en,
  input logic              filter_en,
  input logic              flag_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_extra,
  input logic              rx_done
);
  // R6: flag is sticky until cleared
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !flag_clr) |=> rx_done);

  // R5: a pending flag freezes the delivered data
  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !flag_clr) |=> ($stable(rx_data) && $stable(rx_extra)));

  // R5: outputs change only together with a new delivery
  assert_load_only_R5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rx_data) || !$stable(rx_extra)) |-> $rose(rx_done));

  // R5: with filtering on, a delivered frame has extra bit 1
  assert_filter_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_done) && $past(filter_en)) |-> rx_extra);

  // R8: no delivery while disabled
  assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !$rose(rx_done));

  // R7: deliveries happen only on a tick
  assert_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(tick));
endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       rx_en = 1'b1;
  logic       fmt11 = 1'b0;
  logic       filter_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_extra;
  logic       rx_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic mid_done, end_done;

  mpuart_rx u_dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line), .rx_en(rx_en),
    .fmt11(fmt11), .filter_en(filter_en), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_extra(rx_extra), .rx_done(rx_done)
  );

  always #2 clk = ~clk;

  // tick every 4 clocks, driven away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    tick = (cyc % 4 == 0);
  end

  // ---------------- behavioural reference model ----------------
  logic m_s1 = 1, m_s2 = 1, m_prev = 1;
  int   m_mode = 0;      // 0 hunt, 1 bits, 2 tail
  int   m_t = 0;
  logic m_a = 1, m_b = 1;
  logic m_q[$];
  logic [7:0] m_data = 0;
  logic m_extra = 0, m_done = 0;

  always @(posedge clk) begin
    logic ln, od, v;
    int ph, bi;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_mode = 0; m_t = 0;
      m_data = 0; m_extra = 0; m_done = 0; m_q.delete();
    end else begin
      ln = m_s2;
      m_s2 = m_s1;
      m_s1 = rx_line;
      od = m_done;
      if (flag_clr) m_done = 0;
      if (!rx_en) m_mode = 0;
      else if (tick) begin
        if (m_mode == 0) begin
          if (m_prev && !ln) begin m_mode = 1; m_t = 0; m_q.delete(); end
        end else begin
          m_t = m_t + 1;
          ph = m_t % 16;
          bi = m_t / 16;
          if (m_mode == 1) begin
            if (ph == 7) m_a = ln;
            if (ph == 8) m_b = ln;
            if (ph == 9) begin
              v = (int'(m_a) + int'(m_b) + int'(ln)) >= 2;
              if (bi == 0 && v) m_mode = 0;
              else if (bi < 9) m_q.push_back(v);
              else begin
                if (!od && (!filter_en || v)) begin
                  for (int k = 0; k < 8; k++) m_data[k] = m_q[k+1];
                  m_extra = v;
                  m_done = 1;
                end
                m_mode = fmt11 ? 2 : 0;
              end
            end
          end else if (ph == 9) begin
            m_mode = 0;
          end
        end
      end
      if (tick) m_prev = ln;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rx_data !== m_data || rx_extra !== m_extra || rx_done !== m_done) begin
        errors++;
        $display("FAIL R7 R9 model compare at cycle %0d: actual %h/%b/%b expected %h/%b/%b",
                 cyc, rx_data, rx_extra, rx_done, m_data, m_extra, m_done);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nine, input logic stp,
                            input logic f11, input int gl_bit);
    logic b[11];
    int n;
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) b[i+1] = d[i];
    if (f11) begin b[9] = nine; b[10] = stp; n = 11; end
    else begin b[9] = stp; n = 10; end
    for (int i = 0; i < n; i++) begin
      rx_line = b[i];
      if (i == n - 1) begin
        wclk(20); mid_done = rx_done;
        wclk(43); end_done = rx_done;
        wclk(1);
      end else if (i == gl_bit) begin
        wclk(30); rx_line = ~b[i];
        wclk(4);  rx_line = b[i];
        wclk(30);
      end else begin
        wclk(64);
      end
    end
    rx_line = 1'b1;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; wclk(1); flag_clr = 1'b0;
  endtask

  function automatic logic [9:0] outs();
    return {rx_done, rx_extra, rx_data};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    wclk(150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    wclk(5);
    chk("R1 during reset", outs(), 10'h000);
    rst = 1'b0;
    wclk(100);
    chk("R1 after reset", outs(), 10'h000);

    // R2 / R7: short format, flag rises mid stop bit
    send_frame(8'hA5, 1'b0, 1'b1, 1'b0, -1);
    wclk(64);
    chk("R7 flag low early in stop bit", {9'd0, mid_done}, 10'd0);
    chk("R7 flag high by end of stop bit", {9'd0, end_done}, 10'd1);
    chk("R2 short frame delivered", outs(), {1'b1, 1'b1, 8'hA5});

    // R5: flag pending, new frame lost
    send_frame(8'h3C, 1'b0, 1'b1, 1'b0, -1);
    wclk(64);
    chk("R5 frame lost while flag set", outs(), {1'b1, 1'b1, 8'hA5});

    // R6: clear
    pulse_clr();
    wclk(2);
    chk("R6 flag cleared", outs(), {1'b0, 1'b1, 8'hA5});

    // R5: filter on, stop bit 0 in short format
    filter_en = 1'b1;
    send_frame(8'h81, 1'b0, 1'b0, 1'b0, -1);
    wclk(64);
    chk("R5 filtered short frame dropped", outs(), {1'b0, 1'b1, 8'hA5});

    // R2: filter off, stop bit 0 lands in extra
    filter_en = 1'b0;
    send_frame(8'h81, 1'b0, 1'b0, 1'b0, -1);
    wclk(64);
    chk("R2 stop bit into extra", outs(), {1'b1, 1'b0, 8'h81});
    pulse_clr();

    // long format with filter
    fmt11 = 1'b1; filter_en = 1'b1;
    send_frame(8'h11, 1'b0, 1'b1, 1'b1, -1);
    wclk(64);
    chk("R5 data frame filtered out", outs(), {1'b0, 1'b0, 8'h81});
    send_frame(8'h5A, 1'b1, 1'b1, 1'b1, -1);
    wclk(64);
    chk("R2 long frame ninth bit into extra", outs(), {1'b1, 1'b1, 8'h5A});
    pulse_clr();

    // R7: back-to-back long frames, flag cleared during the second
    filter_en = 1'b0;
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1, -1);
    chk("R2 first back-to-back frame", outs(), {1'b1, 1'b0, 8'hC3});
    fork
      send_frame(8'h96, 1'b1, 1'b1, 1'b1, -1);
      begin wclk(300); pulse_clr(); end
    join
    wclk(64);
    chk("R7 second back-to-back frame received", outs(), {1'b1, 1'b1, 8'h96});
    pulse_clr();

    // R3: false start
    fmt11 = 1'b0;
    rx_line = 1'b0; wclk(12); rx_line = 1'b1;
    wclk(200);
    chk("R3 false start ignored", outs(), {1'b0, 1'b1, 8'h96});
    send_frame(8'h42, 1'b0, 1'b1, 1'b0, -1);
    wclk(64);
    chk("R3 recovery after false start", outs(), {1'b1, 1'b1, 8'h42});
    pulse_clr();

    // R4: one-tick glitch inside data bit 4
    send_frame(8'hF0, 1'b0, 1'b1, 1'b0, 4);
    wclk(64);
    chk("R4 majority rejects glitch", outs(), {1'b1, 1'b1, 8'hF0});
    pulse_clr();

    // R8: disabled receiver
    rx_en = 1'b0;
    send_frame(8'h77, 1'b0, 1'b1, 1'b0, -1);
    wclk(64);
    chk("R8 frame ignored while disabled", outs(), {1'b0, 1'b1, 8'hF0});
    rx_en = 1'b1;
    wclk(64);
    send_frame(8'h0F, 1'b0, 1'b1, 1'b0, -1);
    wclk(64);
    chk("R8 frame received after enable", outs(), {1'b1, 1'b1, 8'h0F});

    wclk(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule